// File: doc/BRIEF.md
# Shift-Register Handshake Transfer Controller

This block is the device end of a byte-serial link to a host processor. The host owns two active-low handshake lines on a shared 8-bit port: transfer-in-progress (bit 5) and transfer-acknowledge (bit 4). The device answers on an active-low request line (bit 3). Bytes travel through an 8-bit shift register. Each port update the host makes is presented to the block as a strobe together with the new port image. The block compares that image with the one it saw at the previous update, and from the comparison it decides whether to capture the shift-register byte into its receive buffer or to present the next pending byte from its transmit buffer.

The block also tracks the idle handshake. While no transfer is running, the request line follows the acknowledge line, and the block reports when a host packet has finished. It raises a shift-register interrupt for every step it takes. The interrupt is normally held back by a fixed delay of about 300 microseconds, counted in clock cycles. Each new request restarts the delay. The interrupt fires at once when the delay parameter is zero or when the port direction register holds all ones.

Top module: `sr_link_ctrl`

## Requirements
- R1: After reset the request line is high (inactive), and the load, packet-done and interrupt outputs are low. Bit 3 of the returned port image carries the request level.
- R2: In host-to-device mode (`sr_dir_out` = 1) the shift-register byte is stored in the receive buffer at the next free index. This happens on a port update with in-progress low (bit 5 = 0) where the {bit 5, bit 4} pair differs from the pair seen at the previous update.
- R3: The receive count never exceeds DEPTH. Bytes offered after the buffer is full are dropped and raise no interrupt.
- R4: A port update whose {bit 5, bit 4} pair equals the previous one moves no byte and raises no interrupt.
- R5: In device-to-host mode (`sr_dir_out` = 0) a qualifying update presents the next pending transmit byte on `sr_byte` with a one-cycle `sr_load` pulse, in buffer order. With nothing pending, nothing is presented.
- R6: When the last pending transmit byte has been presented, the request line goes high.
- R7: On an update with in-progress high, previous in-progress high and acknowledge toggled (idle sync), the request line takes the new acknowledge level and an interrupt is raised.
- R8: When in-progress goes from low to high, an interrupt is always raised. If at least one byte was captured, a one-cycle `pkt_done` pulse is given with `pkt_len` equal to the byte count, and the count is then cleared.
- R9: While idle with transmit bytes pending (after `tx_send` with nonzero length, or at an idle or end update), the request line is driven low.
- R10: A delayed interrupt appears as a one-cycle `sr_irq` pulse exactly DELAY_CYC cycles after the request edge (DELAY_CYC = CLK_HZ/1000*DELAY_US/1000). A request arriving while a delay is running restarts it, so only one pulse results.
- R11: If DELAY_CYC is 0 or `port_ddr` is 8'hFF, `sr_irq` pulses in the cycle right after the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_wr | input | 1 | Strobe: the host updated the port |
| port_val | input | 8 | New port image (bit 5 in-progress, bit 4 acknowledge, active low) |
| sr_dir_out | input | 1 | Shift-register direction: 1 host-to-device, 0 device-to-host |
| port_ddr | input | 8 | Port direction register; all ones makes interrupts immediate |
| sr_in | input | 8 | Shift-register byte written by the host |
| tx_wr | input | 1 | Write strobe into the transmit buffer |
| tx_addr | input | TAW | Transmit buffer write index |
| tx_data | input | 8 | Transmit buffer write data |
| tx_send | input | 1 | Start a device-to-host packet of `tx_len` bytes |
| tx_len | input | TCW | Length of the packet to send |
| rx_addr | input | AW | Receive buffer read index |
| rx_byte | output | 8 | Receive buffer byte at `rx_addr` (combinational) |
| sr_load | output | 1 | One-cycle pulse: `sr_byte` holds a new byte for the host |
| sr_byte | output | 8 | Byte presented to the shift register |
| req_n | output | 1 | Request line, active low |
| port_img | output | 8 | Port image with bit 3 replaced by the request level |
| sr_irq | output | 1 | Shift-register interrupt pulse |
| pkt_done | output | 1 | One-cycle pulse: a host packet has been received |
| pkt_len | output | CW | Byte count of the last received packet |

## Verification
Every handshake result is registered at the clock edge that samples the port strobe. The bench drives each update at a falling edge and reads `req_n`, `sr_load`, `sr_byte`, `pkt_done`, `pkt_len` and immediate `sr_irq` at the next falling edge, exactly one edge later. A delayed interrupt is due DELAY_CYC edges after the request edge. The bench therefore confirms it is still low DELAY_CYC-1 falling edges after the update returns and high one edge later. It counts pulses at falling edges and checks the count only after each window has fully elapsed, including the restart case, where it checks between the window the first request would have ended and the window the second one does end.

// File: rtl/sr_link_ctrl.sv
module sr_link_ctrl #(
  parameter int DEPTH    = 16,
  parameter int TX_DEPTH = 16,
  parameter int CLK_HZ   = 250_000_000,
  parameter int DELAY_US = 300,
  localparam int AW  = $clog2(DEPTH),
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int TAW = $clog2(TX_DEPTH),
  localparam int TCW = $clog2(TX_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           port_wr,
  input  logic [7:0]     port_val,
  input  logic           sr_dir_out,
  input  logic [7:0]     port_ddr,
  input  logic [7:0]     sr_in,
  input  logic           tx_wr,
  input  logic [TAW-1:0] tx_addr,
  input  logic [7:0]     tx_data,
  input  logic           tx_send,
  input  logic [TCW-1:0] tx_len,
  input  logic [AW-1:0]  rx_addr,
  output logic [7:0]     rx_byte,
  output logic           sr_load,
  output logic [7:0]     sr_byte,
  output logic           req_n,
  output logic [7:0]     port_img,
  output logic           sr_irq,
  output logic           pkt_done,
  output logic [CW-1:0]  pkt_len
);

  localparam int DELAY_CYC = CLK_HZ / 1000 * DELAY_US / 1000;
  localparam int DW = $clog2(DELAY_CYC + 2);

  logic [7:0]     rx_mem [DEPTH];
  logic [7:0]     tx_mem [TX_DEPTH];
  logic           last_tip, last_ack;
  logic [CW-1:0]  rx_cnt;
  logic [TCW-1:0] tx_idx, tx_cnt;
  logic [DW-1:0]  dly;

  wire tip = port_val[5];
  wire ack = port_val[4];
  wire pair_chg  = {tip, ack} != {last_tip, last_ack};
  wire rx_room   = rx_cnt < CW'(DEPTH);
  wire tx_pend   = tx_idx < tx_cnt;
  wire tx_last   = (tx_idx + 1'b1) >= tx_cnt;

  wire cap       = port_wr & ~tip &  sr_dir_out & pair_chg & rx_room;
  wire give      = port_wr & ~tip & ~sr_dir_out & pair_chg & tx_pend;
  wire sync      = port_wr &  tip &  last_tip & (ack != last_ack);
  wire idle_hold = port_wr &  tip &  last_tip & (ack == last_ack);
  wire fin       = port_wr &  tip & ~last_tip;
  wire irq_req   = cap | give | sync | fin | tx_send;
  wire immediate = (DELAY_CYC == 0) || (port_ddr == 8'hFF);

  wire [TCW-1:0] len_clip = (tx_len > TCW'(TX_DEPTH)) ? TCW'(TX_DEPTH) : tx_len;

  assign rx_byte  = rx_mem[rx_addr];
  assign port_img = {port_val[7:4], req_n, port_val[2:0]};

  always_ff @(posedge clk) begin
    if (cap) rx_mem[rx_cnt[AW-1:0]] <= sr_in;
    if (tx_wr) tx_mem[tx_addr] <= tx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_tip <= 1'b1;
      last_ack <= 1'b1;
      rx_cnt   <= '0;
      tx_idx   <= '0;
      tx_cnt   <= '0;
      req_n    <= 1'b1;
      sr_load  <= 1'b0;
      sr_byte  <= '0;
      pkt_done <= 1'b0;
      pkt_len  <= '0;
    end else begin
      sr_load  <= 1'b0;
      pkt_done <= 1'b0;
      if (port_wr) begin
        last_tip <= tip;
        last_ack <= ack;
      end
      if (cap) rx_cnt <= rx_cnt + 1'b1;
      if (give) begin
        sr_load <= 1'b1;
        sr_byte <= tx_mem[tx_idx[TAW-1:0]];
        tx_idx  <= tx_idx + 1'b1;
        if (tx_last) req_n <= 1'b1;
      end
      if (sync) req_n <= ack;
      if (fin) begin
        if (rx_cnt != '0) begin
          pkt_done <= 1'b1;
          pkt_len  <= rx_cnt;
        end
        rx_cnt <= '0;
      end
      if ((fin | idle_hold) & tx_pend) req_n <= 1'b0;
      if (tx_send) begin
        tx_cnt <= len_clip;
        tx_idx <= '0;
        if (last_tip && len_clip != '0) req_n <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dly    <= '0;
      sr_irq <= 1'b0;
    end else begin
      sr_irq <= 1'b0;
      if (irq_req && immediate) begin
        sr_irq <= 1'b1;
        dly    <= '0;
      end else if (irq_req) begin
        dly <= DW'(DELAY_CYC);
      end else if (dly != '0) begin
        dly <= dly - 1'b1;
        if (dly == DW'(1)) sr_irq <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sr_link_ctrl_chk.sv
module sr_link_ctrl_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          port_wr,
  input logic [7:0]    port_val,
  input logic [7:0]    port_ddr,
  input logic          tx_send,
  input logic          last_tip,
  input logic          last_ack,
  input logic [CW-1:0] rx_cnt,
  input logic          sr_load,
  input logic          req_n,
  input logic          sr_irq,
  input logic          pkt_done,
  input logic [CW-1:0] pkt_len
);

  p_rx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));

  p_no_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && !port_val[5] && port_val[5] == last_tip && port_val[4] == last_ack)
    |=> !sr_load);

  p_load_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sr_load |-> ($past(port_wr) && !$past(port_val[5])));

  p_sync_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && port_val[5] && last_tip && port_val[4] != last_ack && !tx_send)
    |=> (req_n == $past(port_val[4])));

  p_pkt_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> (pkt_len != '0 && $past(port_wr) && $past(port_val[5]) && !$past(last_tip)));

  p_immediate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && $past(port_ddr) == 8'hFF) |-> sr_irq);

endmodule

bind sr_link_ctrl sr_link_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_val(port_val),
  .port_ddr(port_ddr), .tx_send(tx_send), .last_tip(last_tip),
  .last_ack(last_ack), .rx_cnt(rx_cnt), .sr_load(sr_load), .req_n(req_n),
  .sr_irq(sr_irq), .pkt_done(pkt_done), .pkt_len(pkt_len)
);

// File: tb/sr_link_ctrl_tb.sv
module sr_link_ctrl_tb;
  localparam int D = 30;

  logic clk = 0, rst_n = 0;
  logic port_wr = 0, sr_dir_out = 0, tx_wr = 0, tx_send = 0;
  logic [7:0] port_val = 8'h30, port_ddr = 0, sr_in = 0, tx_data = 0;
  logic [1:0] tx_addr = 0, rx_addr = 0;
  logic [2:0] tx_len = 0;
  logic [7:0] rx_byte, sr_byte, port_img, d0_rx, d0_byte, d0_img;
  logic sr_load, req_n, sr_irq, pkt_done, d0_load, d0_req, d0_irq, d0_done;
  logic [2:0] pkt_len, d0_len;
  int vec = 0, bad = 0, irq_cnt = 0, base = 0;

  always #2 clk = ~clk;

  sr_link_ctrl #(.DEPTH(4), .TX_DEPTH(4), .CLK_HZ(100_000), .DELAY_US(300)) u_dut (
    .clk, .rst_n, .port_wr, .port_val, .sr_dir_out, .port_ddr, .sr_in, .tx_wr,
    .tx_addr, .tx_data, .tx_send, .tx_len, .rx_addr, .rx_byte, .sr_load, .sr_byte,
    .req_n, .port_img, .sr_irq, .pkt_done, .pkt_len);

  sr_link_ctrl #(.DEPTH(4), .TX_DEPTH(4), .CLK_HZ(100_000), .DELAY_US(0)) u_dut0 (
    .clk, .rst_n, .port_wr, .port_val, .sr_dir_out, .port_ddr, .sr_in, .tx_wr,
    .tx_addr, .tx_data, .tx_send, .tx_len, .rx_addr, .rx_byte(d0_rx), .sr_load(d0_load),
    .sr_byte(d0_byte), .req_n(d0_req), .port_img(d0_img), .sr_irq(d0_irq),
    .pkt_done(d0_done), .pkt_len(d0_len));

  always @(negedge clk) if (rst_n && sr_irq) irq_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pw(input logic t, input logic a, input logic [7:0] b);
    @(negedge clk);
    port_val = {2'b00, t, a, 4'b0000};
    sr_in = b;
    port_wr = 1;
    @(negedge clk);
    port_wr = 0;
  endtask

  task automatic rx_chk(input string tag, input int i, input int exp);
    rx_addr = 2'(i);
    #1;
    chk(tag, int'(rx_byte), exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    chk("R1 req_n", int'(req_n), 1);
    chk("R1 port_img bit3", int'(port_img[3]), 1);
    chk("R1 sr_irq", int'(sr_irq), 0);
    chk("R1 pkt_done", int'(pkt_done), 0);
    chk("R1 sr_load", int'(sr_load), 0);

    // host-to-device, delayed interrupt
    sr_dir_out = 1;
    base = irq_cnt;
    pw(0, 1, 8'hA1);
    chk("R11 zero delay", int'(d0_irq), 1);
    idle(D - 1);
    chk("R10 not early", int'(sr_irq), 0);
    idle(1);
    chk("R10 on time", int'(sr_irq), 1);
    idle(2);
    chk("R10 one pulse", irq_cnt - base, 1);
    pw(0, 0, 8'hB2);
    idle(19);
    pw(0, 1, 8'hC3);
    idle(25);
    chk("R10 restart", irq_cnt - base, 1);
    idle(10);
    chk("R10 restart fire", irq_cnt - base, 2);
    pw(1, 1, 8'h00);
    chk("R8 pkt_done", int'(pkt_done), 1);
    chk("R8 pkt_len", int'(pkt_len), 3);
    rx_chk("R2 rx0", 0, 8'hA1);
    rx_chk("R2 rx1", 1, 8'hB2);
    rx_chk("R2 rx2", 2, 8'hC3);
    idle(D + 2);
    chk("R8 end irq", irq_cnt - base, 3);
    chk("R9 no pending req", int'(req_n), 1);

    // repeated pair is ignored
    base = irq_cnt;
    pw(0, 1, 8'h11);
    idle(D + 2);
    pw(0, 1, 8'h22);
    idle(D + 2);
    chk("R4 no irq", irq_cnt - base, 1);
    pw(0, 0, 8'h33);
    idle(D + 2);
    pw(1, 0, 8'h00);
    chk("R4 pkt_len", int'(pkt_len), 2);
    rx_chk("R4 rx1", 1, 8'h33);
    idle(D + 2);

    // overflow with immediate interrupts
    port_ddr = 8'hFF;
    for (int i = 0; i < 6; i++) begin
      pw(0, (i % 2 == 0), 8'(8'h40 + i));
      chk($sformatf("R3 R11 irq byte %0d", i), int'(sr_irq), (i < 4) ? 1 : 0);
    end
    pw(1, 0, 8'h00);
    chk("R3 pkt_len capped", int'(pkt_len), 4);
    chk("R8 immediate end irq", int'(sr_irq), 1);
    rx_chk("R3 rx3", 3, 8'h43);

    // empty transfer end
    sr_dir_out = 0;
    pw(0, 1, 8'h00);
    chk("R5 nothing pending", int'(sr_load), 0);
    pw(1, 1, 8'h00);
    chk("R8 empty no pkt", int'(pkt_done), 0);
    chk("R8 empty irq", int'(sr_irq), 1);

    // device-to-host, delayed
    port_ddr = 8'h00;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      tx_wr = 1; tx_addr = 2'(i); tx_data = 8'(8'hD0 + i);
    end
    @(negedge clk);
    tx_wr = 0; tx_send = 1; tx_len = 3;
    @(negedge clk);
    tx_send = 0;
    chk("R9 req low pending", int'(req_n), 0);
    base = irq_cnt;
    idle(D + 2);
    chk("R9 send irq", irq_cnt - base, 1);
    for (int i = 0; i < 3; i++) begin
      pw(0, (i % 2 == 0), 8'h00);
      chk($sformatf("R5 load %0d", i), int'(sr_load), 1);
      chk($sformatf("R5 byte %0d", i), int'(sr_byte), 8'hD0 + i);
      chk($sformatf("R6 req %0d", i), int'(req_n), (i == 2) ? 1 : 0);
      idle(D + 2);
      chk($sformatf("R10 byte irq %0d", i), irq_cnt - base, i + 2);
    end
    pw(0, 0, 8'h00);
    chk("R5 drained", int'(sr_load), 0);
    idle(D + 2);
    chk("R5 drained irq", irq_cnt - base, 4);
    pw(1, 0, 8'h00);
    chk("R8 d2h no pkt", int'(pkt_done), 0);
    idle(D + 2);

    // idle sync
    port_ddr = 8'hFF;
    pw(1, 1, 8'h00);
    chk("R7 req follows 1", int'(req_n), 1);
    chk("R7 irq", int'(sr_irq), 1);
    pw(1, 0, 8'h00);
    chk("R7 req follows 0", int'(req_n), 0);
    chk("R7 port_img bit3", int'(port_img[3]), 0);
    pw(1, 1, 8'h00);
    chk("R7 req back 1", int'(req_n), 1);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule